// File: doc/BRIEF.md
# Real-Time Clock Register Bank with Update Cycle and Interrupt Flags

This block is the register side of a real-time clock. It has 128 bytes of storage, reached through a two-location bus. One bus location holds a pointer, and the other holds the byte that the pointer selects. The storage holds the visible time and date bytes, three alarm bytes, two control bytes, one status byte, one validity byte and free scratch space. An external calendar counter does all of the date arithmetic. This block only tells that counter when to advance, hands it new time values, and copies its current values back into the visible bytes.

Once per second a tick starts an update cycle. An in-progress flag rises, and a fixed number of clock cycles later the visible time bytes are refreshed from the counter. Then the alarm bytes are compared, status flags are posted and the in-progress flag falls. A freeze mode, selected by the top bit of the second control byte, holds the visible bytes still while software writes them. The status byte collects alarm, update-ended and periodic events. Reading it clears it, and its top bit drives the interrupt line.

Top module: `rtc_regbank`

## Requirements
- R1: A write with `bus_addr`=0 sets the pointer to the low 7 bits of `bus_wdata`. Accesses with `bus_addr`=1 write or return the byte at the pointer. With `bus_addr`=0, `bus_rdata` returns 0xFF.
- R2: After reset, byte 10 (control A) is 0x26, byte 11 (control B) is 0x02, byte 12 (status) is 0x00 and byte 13 (validity) is 0x80.
- R3: Bit 7 of control A (update in progress) cannot be written. A write to byte 10 changes only bits 6:0.
- R4: A write to control B with bit 7 (freeze) set clears update in progress. A write that clears freeze while it was set raises `cal_load` in the following cycle.
- R5: Writes to bytes 12 and 13 have no effect. A read of byte 12 returns its value and then clears it to 0x00, unless new events arrive in the same cycle.
- R6: A write to a time byte (index 0, 2, 4, 6, 7, 8 or 9) while freeze is clear raises `cal_load` for one cycle, starting the cycle after the write. `cal_out` carries those seven bytes, packed in that index order from the least significant byte upward.
- R7: A tick on `sec_tick` raises `cal_incr` in the same cycle only if control A bits 6:4 equal 3'b010. Otherwise the tick is ignored completely.
- R8: When a tick is accepted and freeze is clear, update in progress is set at that clock edge. UIP_CYCLES edges later, the time bytes are loaded from `cal_in` (unless freeze is set at that time) and update in progress is cleared. A tick accepted while freeze is set does not raise update in progress.
- R9: At the end of an update with control B bit 5 set, each alarm byte (seconds at index 1, minutes at 3, hours at 5) matches if its bits 7:6 are 2'b11 or if it equals the matching `cal_in` byte. When all three match, 0xA0 is ORed into the status byte.
- R10: At the end of an update with control B bit 4 set, 0x90 is ORed into the status byte.
- R11: A `periodic_pulse` ORs 0xC0 into the status byte when control B bit 6 is set and control A bits 3:0 are nonzero.
- R12: `irq` equals status bit 7. It stays high until the status byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 1 | 0 selects the pointer, 1 selects the data byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only needed for read-to-clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| periodic_pulse | input | 1 | One-cycle pulse from the periodic rate generator |
| rate_code | output | 4 | Control A bits 3:0, sent to the rate generator |
| cal_in | input | 56 | Current counter values, seven bytes |
| cal_out | output | 56 | Visible time bytes, presented for loading |
| cal_load | output | 1 | Counter load request |
| cal_incr | output | 1 | Counter advance request |
| irq | output | 1 | Interrupt, active high |

## Verification
Each result has a fixed due cycle. `cal_incr` follows the tick input in the same cycle. `cal_load` is due one cycle after the write that causes it. Update in progress is due one edge after the tick. The refreshed time bytes, the new status flags and `irq` are due UIP_CYCLES edges after the tick. A read-to-clear takes effect at the edge that ends the read.

The bench drives inputs on the falling edge. A behavioural model steps on the rising edge, and `irq`, `cal_incr` and `cal_load` are compared one nanosecond after every rising edge. Directed register reads are made only after the update window has closed, except for a deliberate read that checks update in progress while the window is still open.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int unsigned IX_SEC   = 0;
  localparam int unsigned IX_ASEC  = 1;
  localparam int unsigned IX_AMIN  = 3;
  localparam int unsigned IX_AHOUR = 5;
  localparam int unsigned IX_CTLA  = 10;
  localparam int unsigned IX_CTLB  = 11;
  localparam int unsigned IX_STAT  = 12;
  localparam int unsigned IX_VALID = 13;
  localparam int unsigned NUM_TIME = 7;
  localparam int unsigned NUM_ALARM = 3;

  localparam logic [7:0] CTLA_INIT  = 8'h26;
  localparam logic [7:0] CTLB_INIT  = 8'h02;
  localparam logic [7:0] VALID_INIT = 8'h80;
  localparam logic [2:0] OSC_RUN    = 3'b010;

  localparam logic [7:0] EV_ALARM = 8'hA0;
  localparam logic [7:0] EV_UPD   = 8'h90;
  localparam logic [7:0] EV_PER   = 8'hC0;

  // Storage index of the k-th time byte: 0,2,4 then 6,7,8,9
  function automatic int unsigned time_index(int unsigned k);
    return (k < 3) ? 2 * k : k + 3;
  endfunction
endpackage

// File: rtl/rtc_uip_timer.sv
module rtc_uip_timer #(
  parameter int unsigned UIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(UIP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_window_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NUM_FIELDS = 3
) (
  input  logic [NUM_FIELDS*8-1:0] alarm_bytes,
  input  logic [NUM_FIELDS*8-1:0] now_bytes,
  output logic                    hit
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic [7:0] al;
    assign al = alarm_bytes[8*i +: 8];
    // Both top bits set turns the field into a wildcard
    assign fld_ok[i] = (al[7:6] == 2'b11) || (al == now_bytes[8*i +: 8]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
#(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned UIP_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic                  sec_tick,
  input  logic                  periodic_pulse,
  output logic [3:0]            rate_code,
  input  logic [NUM_TIME*8-1:0] cal_in,
  output logic [NUM_TIME*8-1:0] cal_out,
  output logic                  cal_load,
  output logic                  cal_incr,
  output logic                  irq
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] I_CTLA  = AW'(IX_CTLA);
  localparam logic [AW-1:0] I_CTLB  = AW'(IX_CTLB);
  localparam logic [AW-1:0] I_STAT  = AW'(IX_STAT);
  localparam logic [AW-1:0] I_VALID = AW'(IX_VALID);

  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    mem_d [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;
  logic          load_q, load_d;

  logic wr_ptr, wr_dat, rd_dat;
  logic freeze, osc_run, tick_go;
  logic upd_busy, upd_done, alarm_hit;
  logic ptr_is_time;
  logic [7:0] new_ev;

  assign wr_ptr  = bus_wr && !bus_addr;
  assign wr_dat  = bus_wr && bus_addr;
  assign rd_dat  = bus_rd && bus_addr;
  assign freeze  = mem_q[IX_CTLB][7];
  assign osc_run = (mem_q[IX_CTLA][6:4] == OSC_RUN);
  assign tick_go = sec_tick && osc_run;

  always_comb begin
    ptr_is_time = 1'b0;
    for (int unsigned k = 0; k < NUM_TIME; k++)
      if (ptr_q == AW'(time_index(k))) ptr_is_time = 1'b1;
  end

  rtc_uip_timer #(.UIP_CYCLES(UIP_CYCLES)) u_uip (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tick_go),
    .busy  (upd_busy),
    .done  (upd_done)
  );

  rtc_alarm_cmp #(.NUM_FIELDS(NUM_ALARM)) u_alarm (
    .alarm_bytes ({mem_q[IX_AHOUR], mem_q[IX_AMIN], mem_q[IX_ASEC]}),
    .now_bytes   (cal_in[NUM_ALARM*8-1:0]),
    .hit         (alarm_hit)
  );

  always_comb begin
    new_ev = 8'h00;
    if (upd_done && mem_q[IX_CTLB][5] && alarm_hit) new_ev = new_ev | EV_ALARM;
    if (upd_done && mem_q[IX_CTLB][4])              new_ev = new_ev | EV_UPD;
    if (periodic_pulse && mem_q[IX_CTLB][6] && (mem_q[IX_CTLA][3:0] != 4'd0))
      new_ev = new_ev | EV_PER;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    ptr_d  = ptr_q;
    load_d = 1'b0;
    if (wr_ptr) ptr_d = bus_wdata[AW-1:0];
    if (wr_dat) begin
      if (ptr_q == I_CTLA) begin
        mem_d[IX_CTLA] = {mem_q[IX_CTLA][7], bus_wdata[6:0]};
      end else if (ptr_q == I_CTLB) begin
        if (bus_wdata[7]) mem_d[IX_CTLA][7] = 1'b0;
        if (freeze && !bus_wdata[7]) load_d = 1'b1;
        mem_d[IX_CTLB] = bus_wdata;
      end else if (ptr_q != I_STAT && ptr_q != I_VALID) begin
        mem_d[ptr_q] = bus_wdata;
        if (ptr_is_time && !freeze) load_d = 1'b1;
      end
    end
    if (tick_go && !upd_busy && !freeze) mem_d[IX_CTLA][7] = 1'b1;
    if (upd_done) begin
      if (!freeze)
        for (int unsigned k = 0; k < NUM_TIME; k++)
          mem_d[time_index(k)] = cal_in[8*k +: 8];
      mem_d[IX_CTLA][7] = 1'b0;
    end
    mem_d[IX_STAT] = ((rd_dat && ptr_q == I_STAT) ? 8'h00 : mem_q[IX_STAT]) | new_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
      mem_q[IX_CTLA]  <= CTLA_INIT;
      mem_q[IX_CTLB]  <= CTLB_INIT;
      mem_q[IX_VALID] <= VALID_INIT;
      ptr_q  <= '0;
      load_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      ptr_q  <= ptr_d;
      load_q <= load_d;
    end
  end

  for (genvar k = 0; k < NUM_TIME; k++) begin : g_out
    assign cal_out[8*k +: 8] = mem_q[time_index(k)];
  end

  assign bus_rdata = bus_addr ? mem_q[ptr_q] : 8'hFF;
  assign rate_code = mem_q[IX_CTLA][3:0];
  assign cal_load  = load_q;
  assign cal_incr  = tick_go;
  assign irq       = mem_q[IX_STAT][7];

  assert_uip_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ptr_q == I_CTLA && !tick_go && !upd_done)
      |=> (mem_q[IX_CTLA][7] == $past(mem_q[IX_CTLA][7])));
  assert_freeze_release_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ptr_q == I_CTLB && freeze && !bus_wdata[7]) |=> cal_load);
  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && ptr_q == I_STAT && new_ev == 8'h00) |=> !irq);
  assert_valid_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ptr_q == I_VALID) |=> $stable(mem_q[IX_VALID]));
  assert_time_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && ptr_is_time && !freeze) |=> cal_load);
  assert_uip_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !mem_q[IX_CTLA][7]);
  assert_alarm_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && mem_q[IX_CTLB][5] && alarm_hit) |=> (mem_q[IX_STAT][5] && irq));
  assert_update_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && mem_q[IX_CTLB][4]) |=> irq);
endmodule

// File: tb/rtc_regbank_tb_top.sv
`timescale 1ns/1ps
module rtc_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        sec_tick = 1'b0, periodic_pulse = 1'b0;
  logic [3:0]  rate_code;
  logic [55:0] cal_in, cal_out;
  logic        cal_load, cal_incr, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .periodic_pulse(periodic_pulse), .rate_code(rate_code), .cal_in(cal_in),
    .cal_out(cal_out), .cal_load(cal_load), .cal_incr(cal_incr), .irq(irq)
  );

  // Behavioural calendar counter: seconds and minutes in BCD
  logic [7:0] cal [7];
  for (genvar k = 0; k < 7; k++) begin : g_cal
    assign cal_in[8*k +: 8] = cal[k];
  end

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v == 8'h59) return 8'h00;
    if (v[3:0] == 4'd9) return v + 8'd7;
    return v + 8'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 7; k++) cal[k] <= 8'h00;
    end else if (cal_load) begin
      for (int k = 0; k < 7; k++) cal[k] <= cal_out[8*k +: 8];
    end else if (cal_incr) begin
      cal[0] <= bcd_inc(cal[0]);
      if (cal[0] == 8'h59) cal[1] <= bcd_inc(cal[1]);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, stepped on each rising edge
  logic [7:0] m_mem [128];
  int m_ptr, m_cnt;
  bit m_busy, m_load;
  localparam int TIMEIX [7] = '{0, 2, 4, 6, 7, 8, 9};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      m_mem[10] = 8'h26; m_mem[11] = 8'h02; m_mem[13] = 8'h80;
      m_ptr = 0; m_busy = 0; m_cnt = 0; m_load = 0;
    end else begin
      bit frz, osc, tk, fin, hit, is_t;
      logic [7:0] ev;
      frz = m_mem[11][7];
      osc = (m_mem[10][6:4] == 3'b010);
      tk  = sec_tick && osc;
      fin = m_busy && (m_cnt == 7);
      hit = 1;
      if (!(m_mem[1][7:6] == 2'b11 || m_mem[1] == cal[0])) hit = 0;
      if (!(m_mem[3][7:6] == 2'b11 || m_mem[3] == cal[1])) hit = 0;
      if (!(m_mem[5][7:6] == 2'b11 || m_mem[5] == cal[2])) hit = 0;
      ev = 0;
      if (fin && m_mem[11][5] && hit) ev |= 8'hA0;
      if (fin && m_mem[11][4]) ev |= 8'h90;
      if (periodic_pulse && m_mem[11][6] && m_mem[10][3:0] != 0) ev |= 8'hC0;
      m_load = 0;
      is_t = 0;
      foreach (TIMEIX[k]) if (TIMEIX[k] == m_ptr) is_t = 1;
      if (bus_rd && bus_addr && m_ptr == 12) m_mem[12] = 0;
      m_mem[12] |= ev;
      if (bus_wr && bus_addr) begin
        if (m_ptr == 10) m_mem[10][6:0] = bus_wdata[6:0];
        else if (m_ptr == 11) begin
          if (bus_wdata[7]) m_mem[10][7] = 0;
          if (frz && !bus_wdata[7]) m_load = 1;
          m_mem[11] = bus_wdata;
        end else if (m_ptr != 12 && m_ptr != 13) begin
          m_mem[m_ptr] = bus_wdata;
          if (is_t && !frz) m_load = 1;
        end
      end
      if (tk && !m_busy && !frz) m_mem[10][7] = 1;
      if (fin) begin
        if (!frz) foreach (TIMEIX[k]) m_mem[TIMEIX[k]] = cal[k];
        m_mem[10][7] = 0;
      end
      if (bus_wr && !bus_addr) m_ptr = bus_wdata[6:0];
      if (fin) m_busy = 0;
      else if (m_busy) m_cnt++;
      else if (tk) begin m_busy = 1; m_cnt = 0; end
    end
  end

  // Per-clock comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R12 irq", irq, m_mem[12][7]);
      check("R7 cal_incr", cal_incr, sec_tick && (m_mem[10][6:4] == 3'b010));
      check("R6/R4 cal_load", cal_load, m_load);
    end
  end

  task automatic wr_reg(input int ix, input int v);
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'(ix);
    @(negedge clk); bus_addr = 1; bus_wdata = 8'(v);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(input int ix, output int v);
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'(ix);
    @(negedge clk); bus_wr = 0; bus_addr = 1; bus_rd = 1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1;
    // R2 reset values
    rd_reg(10, v); check("R2 ctlA", v, 8'h26);
    rd_reg(11, v); check("R2 ctlB", v, 8'h02);
    rd_reg(12, v); check("R2 status", v, 8'h00);
    rd_reg(13, v); check("R2 valid", v, 8'h80);
    // R1 scratch access, pointer masks bit 7, even read
    wr_reg(8'h40, 8'h5A);
    rd_reg(8'hC0, v); check("R1 scratch via masked ptr", v, 8'h5A);
    @(negedge clk); bus_addr = 0; bus_rd = 1; #1 check("R1 even read", bus_rdata, 8'hFF);
    @(negedge clk); bus_rd = 0;
    // R3 UIP read-only
    wr_reg(10, 8'hA5); rd_reg(10, v); check("R3 ctlA write", v, 8'h25);
    wr_reg(10, 8'h26);
    // R5 status/validity ignore writes
    wr_reg(12, 8'hFF); rd_reg(12, v); check("R5 status write ignored", v, 8'h00);
    wr_reg(13, 8'h11); rd_reg(13, v); check("R5 valid write ignored", v, 8'h80);
    // R6 time write loads counter
    wr_reg(0, 8'h30); idle(2); check("R6 counter loaded", cal[0], 8'h30);
    // R8 update cycle
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'd10;
    @(negedge clk); bus_wr = 0; bus_addr = 1; sec_tick = 1;
    @(negedge clk); sec_tick = 0; #1 check("R8 uip raised", bus_rdata[7], 1);
    idle(10);
    rd_reg(10, v); check("R8 uip cleared", v, 8'h26);
    rd_reg(0, v); check("R8 seconds refreshed", v, 8'h31);
    // R10 update-ended flag, R5 read-to-clear
    wr_reg(11, 8'h12); tick(); idle(10);
    check("R12 irq after update", irq, 1);
    rd_reg(12, v); check("R10 status", v, 8'h90);
    idle(1); check("R5 irq dropped", irq, 0);
    rd_reg(12, v); check("R5 status cleared", v, 8'h00);
    // R9 alarm with wildcards
    wr_reg(1, 8'hC0); wr_reg(3, 8'h00); wr_reg(5, 8'hC5); wr_reg(11, 8'h22);
    tick(); idle(10);
    rd_reg(12, v); check("R9 alarm hit", v, 8'hA0);
    wr_reg(3, 8'h07); tick(); idle(10);
    rd_reg(12, v); check("R9 alarm miss", v, 8'h00);
    // R4 freeze mode
    wr_reg(11, 8'h82);
    rd_reg(0, v); check("R4 seconds before freeze tick", v, 8'h34);
    tick(); idle(10);
    rd_reg(0, v); check("R8 frozen seconds", v, 8'h34);
    rd_reg(10, v); check("R8 no uip in freeze", v, 8'h26);
    wr_reg(0, 8'h10); idle(2); check("R6 no load in freeze", cal[0], 8'h35);
    wr_reg(11, 8'h02); idle(2); check("R4 load on release", cal[0], 8'h10);
    // R7 oscillator stopped
    wr_reg(10, 8'h06); tick(); idle(10);
    check("R7 counter held", cal[0], 8'h10);
    rd_reg(0, v); check("R7 seconds held", v, 8'h10);
    wr_reg(10, 8'h26);
    // R11 periodic events
    wr_reg(11, 8'h42);
    @(negedge clk); periodic_pulse = 1; @(negedge clk); periodic_pulse = 0;
    rd_reg(12, v); check("R11 periodic flag", v, 8'hC0);
    wr_reg(10, 8'h20);
    @(negedge clk); periodic_pulse = 1; @(negedge clk); periodic_pulse = 0;
    rd_reg(12, v); check("R11 rate zero", v, 8'h00);
    check("R11 rate_code", rate_code, 4'h0);
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule